// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block carries out control/status register access operations against a small local bank of 64-bit registers. Each operation supplies a 3-bit function code, a 12-bit register address, a 64-bit source operand, a 5-bit immediate and a flag that marks the source register field as zero. In the same cycle the unit returns the register's current contents for the destination register. At the next clock edge it stores the updated value, but only when the operation calls for a write.

The function code selects the write mode and the operand. The mode is a plain swap, a bit-set or a bit-clear. The operand is either the source value or the zero-extended immediate. The bit-set and bit-clear forms skip the write entirely when their operand is zero. This lets a register be read with no write side effect. The swap form always writes. A write-enable output is high in exactly the cycles in which a write takes place.

Top module: `csr_rmw_unit`

## Requirements
- R1: For function codes 1, 2, 3, 5, 6 and 7 with `opValid` high, `rdData` shows the addressed entry as it was before this operation's write, in the same cycle.
- R2: Function 1 writes `srcVal` to the addressed entry and always writes, even when `srcVal` is zero or `srcIsZero` is high.
- R3: Function 2 writes the old value OR `srcVal`.
- R4: Function 3 writes the old value AND NOT `srcVal`.
- R5: Functions 5, 6 and 7 act as 1, 2 and 3, but their operand is `zimm` zero-extended to 64 bits, and `srcVal` and `srcIsZero` are ignored.
- R6: Functions 2 and 3 do not write when `srcIsZero` is high or `srcVal` is zero. Functions 6 and 7 do not write when `zimm` is zero. `wrEn` stays low in these cases.
- R7: Function codes 0 and 4, and any cycle with `opValid` low, write nothing and drive `rdData` to zero.
- R8: The entry is selected by `csrAddr[2:0]` alone, so the upper address bits do not affect which entry is used.
- R9: Reset clears every entry to zero and holds `wrEn` low.
- R10: `wrEn` is high during exactly the cycle of an operation that writes, and low in the cycles that follow unless another write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | An operation is present this cycle |
| func | input | 3 | Function code |
| csrAddr | input | 12 | Register address |
| srcVal | input | 64 | Source register value |
| srcIsZero | input | 1 | Source register field is zero |
| zimm | input | 5 | Immediate operand |
| rdData | output | 64 | Pre-write register contents |
| wrEn | output | 1 | A write occurs at the next edge |

## Verification
The old-value read and the write of the new value fall in the same cycle and target the same entry. The read must therefore show the pre-write contents while the store lands at the closing edge. The bench provokes this by issuing set, clear and swap operations back to back on one entry. It judges each operation by the `rdData` it returns: that value must equal the result the bench's model predicted for the previous operation, never the value being written. Suppressed set/clear operations sit between writes so that the same read path also proves nothing changed.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [2:0] {
    FN_NONE0   = 3'd0,
    FN_SWAP    = 3'd1,
    FN_SET     = 3'd2,
    FN_CLR     = 3'd3,
    FN_NONE4   = 3'd4,
    FN_SWAPIMM = 3'd5,
    FN_SETIMM  = 3'd6,
    FN_CLRIMM  = 3'd7
  } csr_func_e;

  typedef enum logic [1:0] {
    MODE_SWAP = 2'd0,
    MODE_SET  = 2'd1,
    MODE_CLR  = 2'd2
  } csr_mode_e;

  typedef struct packed {
    logic      readEn;
    logic      writeReq;
    logic      condWrite;
    logic      useImm;
    csr_mode_e mode;
  } csr_strobe_t;

endpackage

// File: rtl/csr_rmw_ctrl.sv
module csr_rmw_ctrl
  import csr_rmw_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  func,
  output csr_strobe_t strobe
);

  always_comb begin
    strobe = '{readEn: 1'b0, writeReq: 1'b0, condWrite: 1'b0,
               useImm: 1'b0, mode: MODE_SWAP};
    if (opValid) begin
      unique case (csr_func_e'(func))
        FN_SWAP, FN_SWAPIMM: begin
          strobe.readEn   = 1'b1;
          strobe.writeReq = 1'b1;
          strobe.mode     = MODE_SWAP;
        end
        FN_SET, FN_SETIMM: begin
          strobe.readEn    = 1'b1;
          strobe.writeReq  = 1'b1;
          strobe.condWrite = 1'b1;
          strobe.mode      = MODE_SET;
        end
        FN_CLR, FN_CLRIMM: begin
          strobe.readEn    = 1'b1;
          strobe.writeReq  = 1'b1;
          strobe.condWrite = 1'b1;
          strobe.mode      = MODE_CLR;
        end
        default: ;
      endcase
      strobe.useImm = func[2];
    end
  end

endmodule

// File: rtl/csr_rmw_datapath.sv
module csr_rmw_datapath
  import csr_rmw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 12,
  parameter int IMM_W  = 5,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       strobe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [DATA_W-1:0] srcVal,
  input  logic              srcIsZero,
  input  logic [IMM_W-1:0]  zimm,
  output logic [DATA_W-1:0] rdData,
  output logic              wrEn
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][DATA_W-1:0] bankQ;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] oldVal;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] newVal;
  logic              opZero;

  assign idx    = csrAddr[IDX_W-1:0];
  assign oldVal = bankQ[idx];
  assign rdData = strobe.readEn ? oldVal : '0;

  always_comb begin
    if (strobe.useImm) begin
      operand = {{(DATA_W-IMM_W){1'b0}}, zimm};
      opZero  = (zimm == '0);
    end else begin
      operand = srcVal;
      opZero  = srcIsZero || (srcVal == '0);
    end
  end

  always_comb begin
    unique case (strobe.mode)
      MODE_SET: newVal = oldVal | operand;
      MODE_CLR: newVal = oldVal & ~operand;
      default:  newVal = operand;
    endcase
  end

  assign wrEn = strobe.writeReq && !(strobe.condWrite && opZero);

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankQ[e] <= '0;
      end else if (wrEn && (idx == IDX_W'(e))) begin
        bankQ[e] <= newVal;
      end
    end
  end

  // R2: a register-operand swap leaves the source value in the entry
  p_swap_stores_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && strobe.mode == MODE_SWAP && !strobe.useImm)
      |=> bankQ[$past(idx)] == $past(srcVal));

  // R3: a set never loses a bit that was already high
  p_set_keeps_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && strobe.mode == MODE_SET)
      |=> (bankQ[$past(idx)] & $past(oldVal)) == $past(oldVal));

  // R4: a clear never raises a bit that was low
  p_clear_no_new_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && strobe.mode == MODE_CLR)
      |=> (bankQ[$past(idx)] & ~$past(oldVal)) == '0);

  // R10: with no write the whole bank holds its contents
  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(bankQ));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 12,
  parameter int IMM_W  = 5,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        func,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [DATA_W-1:0] srcVal,
  input  logic              srcIsZero,
  input  logic [IMM_W-1:0]  zimm,
  output logic [DATA_W-1:0] rdData,
  output logic              wrEn
);

  csr_strobe_t strobe;

  csr_rmw_ctrl u_ctrl (
    .opValid (opValid),
    .func    (func),
    .strobe  (strobe)
  );

  csr_rmw_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .csrAddr   (csrAddr),
    .srcVal    (srcVal),
    .srcIsZero (srcIsZero),
    .zimm      (zimm),
    .rdData    (rdData),
    .wrEn      (wrEn)
  );

  // R7: idle or reserved function codes neither read nor write
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid || func == 3'd0 || func == 3'd4) |-> (rdData == '0 && !wrEn));

  // R6: register set/clear with a zero source field never writes
  p_cond_suppress_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (func == 3'd2 || func == 3'd3) && srcIsZero) |-> !wrEn);

  // R2: the register swap form always writes
  p_swap_always_writes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && func == 3'd1) |-> wrEn);

endmodule

// File: tb/tb_csr_rmw_unit.sv
module tb_csr_rmw_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  func = '0;
  logic [11:0] csrAddr = '0;
  logic [63:0] srcVal = '0;
  logic        srcIsZero = 1'b0;
  logic [4:0]  zimm = '0;
  logic [63:0] rdData;
  logic        wrEn;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  csr_rmw_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .func(func), .csrAddr(csrAddr),
    .srcVal(srcVal), .srcIsZero(srcIsZero), .zimm(zimm), .rdData(rdData), .wrEn(wrEn)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  fn;
    logic [11:0] addr;
    logic [63:0] src;
    logic        sz;
    logic [4:0]  imm;
    logic [63:0] expRd;
    logic        expWe;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{4'd2,  3'd1, 12'h001, 64'h0000_0000_F0F0_F0F0, 1'b0, 5'h00, 64'h0,                   1'b1}, // R2
    '{4'd3,  3'd2, 12'h001, 64'h0000_0000_0000_000F, 1'b0, 5'h00, 64'h0000_0000_F0F0_F0F0, 1'b1}, // R3 R1
    '{4'd4,  3'd3, 12'h001, 64'h0000_0000_0000_00F0, 1'b0, 5'h00, 64'h0000_0000_F0F0_F0FF, 1'b1}, // R4
    '{4'd6,  3'd2, 12'h001, 64'h0,                   1'b1, 5'h00, 64'h0000_0000_F0F0_F00F, 1'b0}, // R6
    '{4'd6,  3'd3, 12'h001, 64'h0,                   1'b1, 5'h00, 64'h0000_0000_F0F0_F00F, 1'b0}, // R6
    '{4'd5,  3'd5, 12'h002, 64'h0000_0000_0000_DEAD, 1'b0, 5'h1F, 64'h0,                   1'b1}, // R5
    '{4'd6,  3'd6, 12'h002, 64'h0000_0000_0000_0055, 1'b0, 5'h00, 64'h0000_0000_0000_001F, 1'b0}, // R6
    '{4'd5,  3'd7, 12'h002, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 5'h03, 64'h0000_0000_0000_001F, 1'b1}, // R5
    '{4'd5,  3'd6, 12'h002, 64'h0,                   1'b1, 5'h10, 64'h0000_0000_0000_001C, 1'b1}, // R5
    '{4'd8,  3'd1, 12'h80A, 64'h0,                   1'b1, 5'h00, 64'h0000_0000_0000_001C, 1'b1}, // R8 R2
    '{4'd2,  3'd2, 12'h002, 64'h0,                   1'b1, 5'h00, 64'h0,                   1'b0}, // R2
    '{4'd7,  3'd0, 12'h001, 64'h0000_0000_0000_0005, 1'b0, 5'h05, 64'h0,                   1'b0}, // R7
    '{4'd7,  3'd4, 12'h001, 64'h0000_0000_0000_0005, 1'b0, 5'h05, 64'h0,                   1'b0}, // R7
    '{4'd8,  3'd2, 12'hFF9, 64'h0,                   1'b1, 5'h00, 64'h0000_0000_F0F0_F00F, 1'b0}, // R8
    '{4'd2,  3'd1, 12'h007, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'h00, 64'h0,                   1'b1}, // R2
    '{4'd4,  3'd3, 12'h007, 64'h8000_0000_0000_0001, 1'b0, 5'h00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}, // R4
    '{4'd5,  3'd6, 12'h007, 64'h0,                   1'b0, 5'h01, 64'h7FFF_FFFF_FFFF_FFFE, 1'b1}, // R5
    '{4'd1,  3'd2, 12'h007, 64'h0,                   1'b1, 5'h00, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0}, // R1
    '{4'd6,  3'd2, 12'h001, 64'h0,                   1'b0, 5'h00, 64'h0000_0000_F0F0_F00F, 1'b0}  // R6
  };

  task automatic check(input string tag, input logic [63:0] actRd, input logic actWe,
                       input logic [63:0] expRd, input logic expWe);
    testsRun++;
    if (actRd !== expRd || actWe !== expWe) begin
      testsFailed++;
      $display("FAIL %s: rdData=%h wrEn=%b expected rdData=%h wrEn=%b",
               tag, actRd, actWe, expRd, expWe);
    end
  endtask

  task automatic applyOp(input logic v, input logic [2:0] fn, input logic [11:0] a,
                         input logic [63:0] s, input logic z, input logic [4:0] im);
    @(negedge clk);
    opValid = v; func = fn; csrAddr = a; srcVal = s; srcIsZero = z; zimm = im;
    #2;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #200000ns;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end

  initial begin
    // R9: outputs during reset
    #12;
    check("R9 wrEn low in reset", rdData, wrEn, 64'h0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    // R9: every entry reads zero after reset (suppressed set = pure read)
    for (int e = 0; e < 8; e++) begin
      applyOp(1'b1, 3'd2, 12'(e), 64'h0, 1'b1, 5'h0);
      check($sformatf("R9 entry %0d cleared", e), rdData, wrEn, 64'h0, 1'b0);
    end
    // Vector table, walked in order
    for (int i = 0; i < NVEC; i++) begin
      applyOp(1'b1, VECS[i].fn, VECS[i].addr, VECS[i].src, VECS[i].sz, VECS[i].imm);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), rdData, wrEn,
            VECS[i].expRd, VECS[i].expWe);
    end
    // R10: the pulse drops once the write operation is gone
    applyOp(1'b1, 3'd1, 12'h003, 64'h1234, 1'b0, 5'h0);
    check("R10 write cycle", rdData, wrEn, 64'h0, 1'b1);
    applyOp(1'b0, 3'd1, 12'h003, 64'h9999, 1'b0, 5'h0);
    check("R10 R7 idle after write", rdData, wrEn, 64'h0, 1'b0);
    applyOp(1'b1, 3'd2, 12'h003, 64'h0, 1'b1, 5'h0);
    check("R7 idle swap did not write", rdData, wrEn, 64'h1234, 1'b0);
    // R1: back-to-back on one entry, each sees the previous result
    applyOp(1'b1, 3'd6, 12'h003, 64'h0, 1'b0, 5'h01);
    check("R1 chain step 1", rdData, wrEn, 64'h1234, 1'b1);
    applyOp(1'b1, 3'd3, 12'h003, 64'h0000_0000_0000_0030, 1'b0, 5'h0);
    check("R1 chain step 2", rdData, wrEn, 64'h1235, 1'b1);
    applyOp(1'b1, 3'd5, 12'h003, 64'hFFFF, 1'b0, 5'h00);
    check("R1 R2 chain step 3", rdData, wrEn, 64'h1205, 1'b1);
    applyOp(1'b1, 3'd2, 12'h003, 64'h0, 1'b1, 5'h0);
    check("R5 zero immediate swap wrote", rdData, wrEn, 64'h0, 1'b0);
    // R9: reset in mid-run clears written entries
    @(negedge clk);
    opValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    applyOp(1'b1, 3'd2, 12'h007, 64'h0, 1'b1, 5'h0);
    check("R9 entry 7 after second reset", rdData, wrEn, 64'h0, 1'b0);
    applyOp(1'b1, 3'd2, 12'h001, 64'h0, 1'b1, 5'h0);
    check("R9 entry 1 after second reset", rdData, wrEn, 64'h0, 1'b0);
    applyOp(1'b0, 3'd0, 12'h0, 64'h0, 1'b0, 5'h0);
    finish();
  end

endmodule